// File: doc/BRIEF.md
# Cross-Shaped Stencil Window from Chained Row Buffers

This block takes one time step of a 2D grid as a raster stream of present-step values. Each row is `ROW_LEN` consecutive samples. Values arrive through a single input port, at most one per cycle. The block holds the last `2*HALF_W` rows in a chain of row-length delay buffers kept in on-chip RAM, and the newest row passes straight through. With this storage every sample is fetched from external memory once per time step. Arithmetic that needs a cross-shaped neighbourhood of half-width `HALF_W` still sees all the operands of one centre point together.

For each accepted sample the block may present one window. The centre of that window lies `HALF_W` rows plus `HALF_W` samples behind the newest input. The window has two parts. One is a vertical arm: the same column in the `HALF_W` rows above and below. The other is a horizontal arm: the neighbours along the streaming axis on both sides. The grid coordinates of the centre come with the window. Centres far enough from every grid edge are flagged as full windows. Centres that touch the margin are flagged as edge points and carry no usable window. A stall input freezes the whole pipeline. A frame-start pulse lets the next time step begin at once.

Top module: `stencil_cross_window`

## Requirements
- R1: The vertical arm `win_row` holds `2*HALF_W+1` values. Slot i (bits `i*DATA_W` upward) holds the sample at the centre's column in row `centre_row + i - HALF_W`. It is built from `2*HALF_W` chained buffers, and each buffer delays the stream by exactly one row.
- R2: The horizontal arm `win_col` holds `2*HALF_W+1` values. Slot i holds the sample at column `centre_col + i - HALF_W` of the centre's row. Slot `HALF_W` of either arm is the centre itself.
- R3: Index samples in raster order as n = row*ROW_LEN + col. The window for centre index s appears in the cycle after the sample with index s + HALF_W*ROW_LEN + HALF_W is accepted. Accepts of samples with index below HALF_W*ROW_LEN + HALF_W raise no flag.
- R4: `out_valid` is high only for centres whose row lies in [HALF_W, NUM_ROWS-1-HALF_W] and whose column lies in [HALF_W, ROW_LEN-1-HALF_W].
- R5: Emitted centres outside that interior raise `out_edge` instead of `out_valid`. The two flags are never high together.
- R6: A cycle with `stall` high, or with `in_valid` low, accepts nothing. In the next cycle both flags are low and both arms hold their values. No sample is lost or duplicated across the stall.
- R7: A `frame_start` pulse clears the position count. A sample accepted together with the pulse is index 0. A pulse without an accept makes the next accepted sample index 0.
- R8: `out_row` and `out_col` give the centre's row and column for every emitted window, valid or edge.
- R9: After synchronous active-low reset, both flags are low and both coordinates are 0.
- R10: After NUM_ROWS*ROW_LEN accepted samples the position count returns to index 0 without a `frame_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A present-step sample is offered |
| in_data | input | DATA_W | Sample value |
| stall | input | 1 | Freeze all buffers and shift stages this cycle |
| frame_start | input | 1 | Restart position counting for a new time step |
| out_valid | output | 1 | Full interior window present this cycle |
| out_edge | output | 1 | Emitted centre lies in the edge margin |
| out_row | output | $clog2(NUM_ROWS) | Centre row |
| out_col | output | $clog2(ROW_LEN) | Centre column |
| win_row | output | (2*HALF_W+1)*DATA_W | Vertical arm, slot 0 is the top row |
| win_col | output | (2*HALF_W+1)*DATA_W | Horizontal arm, slot 0 is the leftmost column |

## Verification
The checker watches these properties on every cycle:
- the two flags never rise together;
- a full window always has interior coordinates;
- a stalled or idle cycle is followed by silent flags and frozen arms;
- no window is reported right after a frame restart.

Other behaviour only the bench scenarios can show: that every tap carries the right neighbour, that the delay of one row plus `HALF_W` samples is met, and that nothing is lost across random stalls, aborted frames and the wrap from one frame to the next. The bench covers these for half-widths 1 and 2.

// File: rtl/sbw_pkg.sv
// Shared sizing helpers for the cross-shaped stencil window.
// Assumes the half-width is at least 1.
package sbw_pkg;
    // Number of taps along one arm of the cross.
    function automatic int arm_taps(input int half_w);
        return 2 * half_w + 1;
    endfunction
endpackage

// File: rtl/sbw_row_fifo.sv
// One-row delay buffer: the output register holds the input seen exactly
// ROW_LEN accepted cycles earlier. ROW_LEN-1 entries sit in RAM with a
// synchronous read, plus one output register. Assumes ROW_LEN >= 3.
module sbw_row_fifo #(
    parameter int DATA_W  = 16,
    parameter int ROW_LEN = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    localparam int RAM_D = ROW_LEN - 1;
    localparam int PTR_W = $clog2(RAM_D);

    logic [DATA_W-1:0] ram [RAM_D];
    logic [PTR_W-1:0]  ptr;

    // RAM write port: store the incoming value at the circular pointer.
    always_ff @(posedge clk) begin
        if (adv) ram[ptr] <= din;
    end

    // Read the oldest entry out and step the pointer around the ring.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr  <= '0;
            dout <= '0;
        end else if (adv) begin
            dout <= ram[ptr];
            ptr  <= (ptr == PTR_W'(RAM_D - 1)) ? '0 : ptr + 1'b1;
        end
    end
endmodule

// File: rtl/sbw_shift.sv
// Register shift chain of DEPTH stages that advance together on adv.
// Stage i (flat slot i) holds the input from i+1 accepted cycles earlier.
module sbw_shift #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    adv,
    input  logic [DATA_W-1:0]       din,
    output logic [DEPTH*DATA_W-1:0] stages
);
    logic [DEPTH-1:0][DATA_W-1:0] sr;

    // Shift every stage by one place per accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr <= '0;
        end else if (adv) begin
            sr[0] <= din;
            for (int i = 1; i < DEPTH; i++) sr[i] <= sr[i-1];
        end
    end

    assign stages = sr;
endmodule

// File: rtl/sbw_scan_ctr.sv
// Tracks the raster position of each accepted sample. Derives the centre
// that lags by HALF_W rows plus HALF_W samples, and registers its flags and
// coordinates. Assumes NUM_ROWS and ROW_LEN are both above 2*HALF_W.
module sbw_scan_ctr #(
    parameter int HALF_W   = 1,
    parameter int ROW_LEN  = 64,
    parameter int NUM_ROWS = 64,
    localparam int ROW_W   = $clog2(NUM_ROWS),
    localparam int COL_W   = $clog2(ROW_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             frame_start,
    output logic             out_valid,
    output logic             out_edge,
    output logic [ROW_W-1:0] out_row,
    output logic [COL_W-1:0] out_col
);
    logic [ROW_W-1:0] nxt_row, cur_row;
    logic [COL_W-1:0] nxt_col, cur_col;
    int row_i, col_i, cen_r, cen_c;
    logic primed, interior;

    // Position of the sample being offered this cycle.
    assign cur_row = frame_start ? '0 : nxt_row;
    assign cur_col = frame_start ? '0 : nxt_col;

    // Centre position and its classification.
    always_comb begin
        row_i  = int'(cur_row);
        col_i  = int'(cur_col);
        primed = (row_i > HALF_W) || (row_i == HALF_W && col_i >= HALF_W);
        if (col_i >= HALF_W) begin
            cen_c = col_i - HALF_W;
            cen_r = row_i - HALF_W;
        end else begin
            cen_c = col_i + ROW_LEN - HALF_W;
            cen_r = row_i - HALF_W - 1;
        end
        interior = (cen_r >= HALF_W) && (cen_r <= NUM_ROWS - 1 - HALF_W) &&
                   (cen_c >= HALF_W) && (cen_c <= ROW_LEN - 1 - HALF_W);
    end

    // Advance the raster position with wrap at the end of the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nxt_row <= '0;
            nxt_col <= '0;
        end else if (adv) begin
            if (cur_col == COL_W'(ROW_LEN - 1)) begin
                nxt_col <= '0;
                nxt_row <= (cur_row == ROW_W'(NUM_ROWS - 1)) ? '0 : cur_row + 1'b1;
            end else begin
                nxt_col <= cur_col + 1'b1;
                nxt_row <= cur_row;
            end
        end else if (frame_start) begin
            nxt_row <= '0;
            nxt_col <= '0;
        end
    end

    // Register the flags and coordinates of the centre emitted this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_edge  <= 1'b0;
            out_row   <= '0;
            out_col   <= '0;
        end else begin
            out_valid <= adv && primed && interior;
            out_edge  <= adv && primed && !interior;
            if (adv && primed) begin
                out_row <= ROW_W'(cen_r);
                out_col <= COL_W'(cen_c);
            end
        end
    end
endmodule

// File: rtl/stencil_cross_window.sv
// Cross-shaped stencil window of half-width HALF_W over a raster stream.
// 2*HALF_W chained one-row buffers supply the vertical arm, and a shift
// chain on the middle tap supplies the horizontal arm. Every vertical tap
// is delayed HALF_W samples so that all taps share the centre column.
// Assumes ROW_LEN and NUM_ROWS exceed 2*HALF_W.
module stencil_cross_window #(
    parameter int DATA_W   = 16,
    parameter int ROW_LEN  = 64,
    parameter int NUM_ROWS = 64,
    parameter int HALF_W   = 1,
    localparam int TAPS    = sbw_pkg::arm_taps(HALF_W),
    localparam int ROW_W   = $clog2(NUM_ROWS),
    localparam int COL_W   = $clog2(ROW_LEN)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [DATA_W-1:0]      in_data,
    input  logic                   stall,
    input  logic                   frame_start,
    output logic                   out_valid,
    output logic                   out_edge,
    output logic [ROW_W-1:0]       out_row,
    output logic [COL_W-1:0]       out_col,
    output logic [TAPS*DATA_W-1:0] win_row,
    output logic [TAPS*DATA_W-1:0] win_col
);
    logic adv;
    logic [DATA_W-1:0] tap0_q;
    logic [TAPS-1:0][DATA_W-1:0] tap;
    logic [2*HALF_W*DATA_W-1:0] hs_flat;

    assign adv = in_valid && !stall;

    // Newest-row tap: register the accepted input.
    always_ff @(posedge clk) begin
        if (!rst_n)   tap0_q <= '0;
        else if (adv) tap0_q <= in_data;
    end
    assign tap[0] = tap0_q;

    // Chain of one-row buffers: tap k lags tap 0 by k rows.
    for (genvar k = 1; k < TAPS; k++) begin : g_rows
        logic [DATA_W-1:0] q;
        sbw_row_fifo #(.DATA_W(DATA_W), .ROW_LEN(ROW_LEN)) u_fifo (
            .clk(clk), .rst_n(rst_n), .adv(adv), .din(tap[k-1]), .dout(q)
        );
        assign tap[k] = q;
    end

    // Horizontal arm: delay chain on the middle (centre-row) tap.
    sbw_shift #(.DATA_W(DATA_W), .DEPTH(2*HALF_W)) u_hshift (
        .clk(clk), .rst_n(rst_n), .adv(adv), .din(tap[HALF_W]), .stages(hs_flat)
    );

    // Horizontal slot i takes the sample (2*HALF_W - i) accepts back.
    for (genvar i = 0; i < TAPS; i++) begin : g_hwin
        if (i == TAPS - 1) begin : g_new
            assign win_col[i*DATA_W +: DATA_W] = tap[HALF_W];
        end else begin : g_old
            assign win_col[i*DATA_W +: DATA_W] = hs_flat[(TAPS-2-i)*DATA_W +: DATA_W];
        end
    end

    // Vertical slot i comes from tap 2*HALF_W-i, aligned by HALF_W samples.
    for (genvar i = 0; i < TAPS; i++) begin : g_vwin
        if (i == HALF_W) begin : g_mid
            assign win_row[i*DATA_W +: DATA_W] = hs_flat[(HALF_W-1)*DATA_W +: DATA_W];
        end else begin : g_arm
            logic [HALF_W*DATA_W-1:0] vd;
            sbw_shift #(.DATA_W(DATA_W), .DEPTH(HALF_W)) u_vdly (
                .clk(clk), .rst_n(rst_n), .adv(adv), .din(tap[TAPS-1-i]), .stages(vd)
            );
            assign win_row[i*DATA_W +: DATA_W] = vd[(HALF_W-1)*DATA_W +: DATA_W];
        end
    end

    // Centre position, classification and output flags.
    sbw_scan_ctr #(.HALF_W(HALF_W), .ROW_LEN(ROW_LEN), .NUM_ROWS(NUM_ROWS)) u_scan (
        .clk(clk), .rst_n(rst_n), .adv(adv), .frame_start(frame_start),
        .out_valid(out_valid), .out_edge(out_edge), .out_row(out_row), .out_col(out_col)
    );
endmodule

// File: rtl/sbw_window_chk.sv
// Protocol checker for the cross-shaped stencil window, bound to the top.
module sbw_window_chk #(
    parameter int DATA_W   = 16,
    parameter int ROW_LEN  = 64,
    parameter int NUM_ROWS = 64,
    parameter int HALF_W   = 1,
    localparam int TAPS    = 2 * HALF_W + 1,
    localparam int ROW_W   = $clog2(NUM_ROWS),
    localparam int COL_W   = $clog2(ROW_LEN)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   in_valid,
    input logic                   stall,
    input logic                   frame_start,
    input logic                   out_valid,
    input logic                   out_edge,
    input logic [ROW_W-1:0]       out_row,
    input logic [COL_W-1:0]       out_col,
    input logic [TAPS*DATA_W-1:0] win_row,
    input logic [TAPS*DATA_W-1:0] win_col
);
    // R5
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && out_edge));

    // R4
    interior_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (int'(out_row) >= HALF_W && int'(out_row) <= NUM_ROWS - 1 - HALF_W &&
                       int'(out_col) >= HALF_W && int'(out_col) <= ROW_LEN - 1 - HALF_W));

    // R6
    stall_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && !stall) |=> (!out_valid && !out_edge));

    // R6
    stall_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && !stall) |=> ($stable(win_row) && $stable(win_col)));

    // R7
    restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && in_valid && !stall) |=> (!out_valid && !out_edge));
endmodule

bind stencil_cross_window sbw_window_chk #(
    .DATA_W(DATA_W), .ROW_LEN(ROW_LEN), .NUM_ROWS(NUM_ROWS), .HALF_W(HALF_W)
) u_window_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .stall(stall),
    .frame_start(frame_start), .out_valid(out_valid), .out_edge(out_edge),
    .out_row(out_row), .out_col(out_col), .win_row(win_row), .win_col(win_col)
);

// File: tb/stencil_cross_window_bench.sv
// One configuration of the window under test, with its own stimulus and
// reference model.
module scw_harness #(
    parameter int M    = 1,
    parameter int L    = 8,
    parameter int NR   = 6,
    parameter int SEED = 1
) (
    input  logic clk,
    input  logic rst_n,
    output logic done,
    output int   n_chk,
    output int   n_fail
);
    localparam int DW = 16;
    localparam int T  = 2 * M + 1;
    localparam int FR = NR * L;

    logic in_valid, stall, frame_start;
    logic [DW-1:0] in_data;
    logic out_valid, out_edge;
    logic [$clog2(NR)-1:0] out_row;
    logic [$clog2(L)-1:0]  out_col;
    logic [T*DW-1:0] win_row, win_col, prev_row, prev_col;

    stencil_cross_window #(.DATA_W(DW), .ROW_LEN(L), .NUM_ROWS(NR), .HALF_W(M))
    u_stencil_cross_window (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .stall(stall), .frame_start(frame_start), .out_valid(out_valid),
        .out_edge(out_edge), .out_row(out_row), .out_col(out_col),
        .win_row(win_row), .win_col(win_col)
    );

    logic [DW-1:0] img [FR];
    int    nx;
    int    base;
    string ctag;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s (m=%0d): actual %0d expected %0d", req, M, act, exp);
        end
    endtask

    // One cycle: drive, clock, then compare at the falling edge.
    task automatic step(input bit v, input bit st, input bit fs);
        bit acc;
        int n, s, r, c;
        bit intr;
        acc = v && !st;
        n = 0;
        if (fs) nx = 0;
        if (acc) begin
            n = nx;
            img[n] = DW'(base + n);
            nx = (n + 1) % FR;
        end
        in_valid = v; stall = st; frame_start = fs; in_data = DW'(base + n);
        prev_row = win_row; prev_col = win_col;
        @(posedge clk);
        @(negedge clk);
        if (!acc) begin
            chk(!out_valid && !out_edge, "R6", {out_valid, out_edge}, 0);
            chk(win_row == prev_row && win_col == prev_col, "R6", 0, 0);
        end else if (n < M * L + M) begin
            chk(!out_valid && !out_edge, "R3", {out_valid, out_edge}, 0);
        end else begin
            s = n - M * L - M;
            r = s / L; c = s % L;
            intr = (r >= M) && (r <= NR - 1 - M) && (c >= M) && (c <= L - 1 - M);
            chk(out_valid == intr, "R4", out_valid, intr);
            chk(out_edge == !intr, "R5", out_edge, !intr);
            chk(int'(out_row) == r && int'(out_col) == c, ctag,
                int'(out_row) * 1000 + int'(out_col), r * 1000 + c);
            if (intr) begin
                for (int i = 0; i < T; i++) begin
                    chk(win_row[i*DW +: DW] == img[s + (i - M) * L], "R1",
                        win_row[i*DW +: DW], img[s + (i - M) * L]);
                    chk(win_col[i*DW +: DW] == img[s + i - M], "R2",
                        win_col[i*DW +: DW], img[s + i - M]);
                end
            end
        end
    endtask

    // Stream `count` samples, with random gaps and stalls when asked.
    task automatic stream(input int count, input bit gaps, input bit fs_first);
        int got;
        bit fs, v, st;
        got = 0;
        fs = fs_first;
        while (got < count) begin
            v  = gaps ? ($urandom % 4 != 0) : 1'b1;
            st = gaps ? ($urandom % 5 == 0) : 1'b0;
            step(v, st, fs);
            fs = 1'b0;
            if (v && !st) got++;
        end
    endtask

    initial begin
        void'($urandom(SEED));
        done = 0; n_chk = 0; n_fail = 0; nx = 0; base = 0; ctag = "R8";
        in_valid = 0; stall = 0; frame_start = 0; in_data = '0;
        wait (rst_n === 1'b1);
        @(negedge clk);
        // R9: reset state
        chk(!out_valid && !out_edge, "R9", {out_valid, out_edge}, 0);
        chk(out_row == 0 && out_col == 0, "R9", int'(out_row) + int'(out_col), 0);
        // Gapless frame, then the next frame by wrap only (R10).
        base = 1000; ctag = "R7";
        stream(FR, 1'b0, 1'b1);
        base = 3000; ctag = "R10";
        stream(FR, 1'b0, 1'b0);
        // Random gaps and stalls across two frames (R6).
        base = 5000 + int'($urandom % 1000); ctag = "R8";
        stream(FR, 1'b1, 1'b1);
        stream(FR, 1'b1, 1'b0);
        // Abort half-way with a restart pulse on a sample (R7).
        base = 8000; ctag = "R7";
        stream(FR / 2 + 3, 1'b1, 1'b0);
        base = 12000;
        stream(FR, 1'b1, 1'b1);
        // Restart pulse while stalled, then a frame (R7).
        base = 20000;
        step(1'b1, 1'b1, 1'b1);
        stream(FR, 1'b1, 1'b0);
        in_valid = 0; stall = 0; frame_start = 0;
        done = 1;
    end
endmodule

module stencil_cross_window_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic d1, d2;
    int c1, f1, c2, f2;
    int extra;

    always #5 clk = ~clk;

    scw_harness #(.M(1), .L(8),  .NR(6), .SEED(17)) u_h1 (
        .clk(clk), .rst_n(rst_n), .done(d1), .n_chk(c1), .n_fail(f1));
    scw_harness #(.M(2), .L(10), .NR(8), .SEED(29)) u_h2 (
        .clk(clk), .rst_n(rst_n), .done(d2), .n_chk(c2), .n_fail(f2));

    initial begin
        extra = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        for (int cyc = 0; cyc < 50000; cyc++) begin
            @(posedge clk);
            if (d1 && d2) break;
        end
        if (!(d1 && d2)) begin
            extra = 1;
            $display("FAIL watchdog: actual not done expected done");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***",
                 c1 + c2 + extra, f1 + f2 + extra);
        $finish;
    end
endmodule